// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Masking

The block watches a set of level-sensitive interrupt request lines and chooses one of them to present to the processor. Software assigns every source a 4-bit priority through a small write-only register bus. Most sources have a private priority field. Some sources are grouped in pairs that share a field. The highest programmed level among the active requests wins. A tie on level goes to the source with the lower index. The winner reaches the processor only when its level is strictly above the 4-bit mask that the processor supplies. Every other active request stays pending and competes again on the next cycle, so no request is lost.

The request, the accepted level and the vector number leave the block from registers, and those registers are reloaded on every cycle. By default the vector is a fixed base plus the winning source index. In external vector mode, a win by one of the externally wired sources takes the vector from an 8-bit input bus instead. The processor side is a plain request/acknowledge pair, not a valid/ready stream, and the processor cannot apply back-pressure. While the request is high, an acknowledge latches one handshake. The request then drops for one cycle with the level and vector held, and arbitration resumes after that cycle.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is held, and after reset is released, `irq_req` is 0, `irq_level` is 0 and `irq_vector` is 0. Every priority field is 0 after reset.
- R2: A write with `reg_addr` = r (0 to 4) stores `reg_wdata`. Bits [4k+3:4k] of that data become field 4r+k. Source i (0 to 15) uses field i. Sources 16+2j and 17+2j share field 16+j. Writes to addresses 5 to 7 change nothing.
- R3: Among the active sources, the one with the highest programmed level is chosen. Requests that lose stay pending.
- R4: On equal levels the lowest source index wins. This includes two sources that share one field.
- R5: The winner is forwarded only if its level is strictly greater than `sr_mask`. At an equal or lower level, the request is held and is forwarded once the mask drops below it.
- R6: A source whose level is 0 is never forwarded.
- R7: In internal mode the vector is 64 + the source index.
- R8: When `ext_vec_mode` = 1 and the winner is source 0 to 3, `irq_vector` equals `ext_vec`. All other sources keep the internal vector.
- R9: The outputs are registered. Inputs applied before a clock edge appear after that edge and not before. When nothing is forwarded, all three outputs are 0.
- R10: If `irq_ack` = 1 while `irq_req` = 1, the next cycle shows `irq_req` = 0 with the level and vector unchanged. Arbitration then resumes on the following edge. An `irq_ack` while `irq_req` = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Priority register write strobe |
| reg_addr | input | 3 | Priority register select |
| reg_wdata | input | 16 | Write data, four 4-bit fields |
| irq_src | input | 24 | Level-sensitive request lines |
| sr_mask | input | 4 | Processor mask level |
| ext_vec_mode | input | 1 | Take vectors of sources 0 to 3 from `ext_vec` |
| ext_vec | input | 8 | External vector number |
| irq_req | output | 1 | Request to processor |
| irq_ack | input | 1 | Acknowledge from processor |
| irq_level | output | 4 | Accepted priority level |
| irq_vector | output | 8 | Vector number |

## Verification
The main function is tried with several kinds of request set. A single active request confirms the level and vector mapping of each field. Pairs with unequal levels show that the winner is chosen by level and not by index. Pairs with equal levels, including two sources that share a field, show that the index breaks the tie. Requests at, just above and below the mask separate the strict comparison from a non-strict one, and lowering the mask shows that a held request was not dropped. External mode is applied to one external and one internal winner, and the acknowledge sequence is run with a new request arriving during the held cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic {
    ST_ARB  = 1'b0,
    ST_HOLD = 1'b1
  } out_state_e;

  // Map a source index to the priority field it reads.
  function automatic int field_of(input int src, input int n_solo, input int grp);
    if (src < n_solo) return src;
    return n_solo + (src - n_solo) / grp;
  endfunction

endpackage

// File: rtl/prio_regs.sv
module prio_regs #(
  parameter int NUM_REGS       = 5,
  parameter int FIELDS_PER_REG = 4,
  parameter int LVL_W          = 4,
  localparam int DATA_W        = FIELDS_PER_REG * LVL_W,
  localparam int ADDR_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int NUM_FIELDS    = NUM_REGS * FIELDS_PER_REG
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  reg_we,
  input  logic [ADDR_W-1:0]                     reg_addr,
  input  logic [DATA_W-1:0]                     reg_wdata,
  output logic [NUM_FIELDS-1:0][LVL_W-1:0]      field_lvl
);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (reg_we && (int'(reg_addr) < NUM_REGS)) begin
      regs_q[reg_addr] <= reg_wdata;
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar k = 0; k < FIELDS_PER_REG; k++) begin : g_fld
      assign field_lvl[r*FIELDS_PER_REG + k] = regs_q[r][k*LVL_W +: LVL_W];
    end
  end

  // R2
  bad_addr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (int'(reg_addr) >= NUM_REGS)) |=> $stable(regs_q));

endmodule

// File: rtl/prio_tree.sv
module prio_tree #(
  parameter int N     = 24,
  parameter int LVL_W = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int DEPTH = (N > 1) ? $clog2(N) : 1,
  localparam int P     = 1 << DEPTH,
  localparam int NODES = 2 * P - 1
) (
  input  logic [N-1:0][LVL_W-1:0] lvl_in,
  output logic [LVL_W-1:0]        win_lvl,
  output logic [IDX_W-1:0]        win_idx
);

  logic [LVL_W-1:0] nl [NODES];
  logic [IDX_W-1:0] ni [NODES];

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign nl[P-1+i] = lvl_in[i];
      assign ni[P-1+i] = IDX_W'(i);
    end else begin : g_pad
      assign nl[P-1+i] = '0;
      assign ni[P-1+i] = '0;
    end
  end

  // Left child always carries lower indices, so >= keeps the lower index on a tie.
  for (genvar n = 0; n < P - 1; n++) begin : g_node
    logic take_left;
    assign take_left = nl[2*n+1] >= nl[2*n+2];
    assign nl[n] = take_left ? nl[2*n+1] : nl[2*n+2];
    assign ni[n] = take_left ? ni[2*n+1] : ni[2*n+2];
  end

  assign win_lvl = nl[0];
  assign win_idx = ni[0];

  logic order_bad;
  always_comb begin
    order_bad = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (lvl_in[i] > win_lvl) order_bad = 1'b1;
      if ((lvl_in[i] == win_lvl) && (lvl_in[i] != '0) && (i < int'(win_idx))) order_bad = 1'b1;
    end
    // R3 R4
    tree_order_chk: assert (!order_bad);
  end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int N        = 24,
  parameter int LVL_W    = 4,
  parameter int VEC_W    = 8,
  parameter int NUM_EXT  = 4,
  parameter int VEC_BASE = 64,
  localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [LVL_W-1:0] sr_mask,
  input  logic             ext_vec_mode,
  input  logic [VEC_W-1:0] ext_vec,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_level,
  output logic [VEC_W-1:0] irq_vector
);
  import irq_arb_pkg::*;

  out_state_e       state_q;
  logic             req_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;

  logic             accept;
  logic             use_ext;
  logic [VEC_W-1:0] nxt_vec;

  assign accept  = win_lvl > sr_mask;
  assign use_ext = ext_vec_mode && (int'(win_idx) < NUM_EXT);
  assign nxt_vec = use_ext ? ext_vec : (VEC_W'(VEC_BASE) + VEC_W'(win_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARB;
      req_q   <= 1'b0;
      lvl_q   <= '0;
      vec_q   <= '0;
    end else if ((state_q == ST_ARB) && irq_ack && req_q) begin
      state_q <= ST_HOLD;
      req_q   <= 1'b0;
    end else begin
      state_q <= ST_ARB;
      req_q   <= accept;
      lvl_q   <= accept ? win_lvl : '0;
      vec_q   <= accept ? nxt_vec : '0;
    end
  end

  assign irq_req    = req_q;
  assign irq_level  = lvl_q;
  assign irq_vector = vec_q;

  // R5
  req_above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level > $past(sr_mask)));

  // R6
  req_level_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level != '0));

  // R10
  ack_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> (!irq_req && $stable(irq_level) && $stable(irq_vector)));

  // R10
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |=> (state_q == ST_ARB));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_REGS       = 5,
  parameter int FIELDS_PER_REG = 4,
  parameter int LVL_W          = 4,
  parameter int NUM_SOLO       = 16,
  parameter int GROUP_SIZE     = 2,
  parameter int NUM_EXT        = 4,
  parameter int VEC_W          = 8,
  parameter int VEC_BASE       = 64,
  localparam int NUM_FIELDS    = NUM_REGS * FIELDS_PER_REG,
  localparam int NUM_SRC       = NUM_SOLO + (NUM_FIELDS - NUM_SOLO) * GROUP_SIZE,
  localparam int DATA_W        = FIELDS_PER_REG * LVL_W,
  localparam int ADDR_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int IDX_W         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [LVL_W-1:0]   sr_mask,
  input  logic               ext_vec_mode,
  input  logic [VEC_W-1:0]   ext_vec,
  output logic               irq_req,
  input  logic               irq_ack,
  output logic [LVL_W-1:0]   irq_level,
  output logic [VEC_W-1:0]   irq_vector
);
  import irq_arb_pkg::*;

  logic [NUM_FIELDS-1:0][LVL_W-1:0] field_lvl;
  logic [NUM_SRC-1:0][LVL_W-1:0]    src_lvl;
  logic [LVL_W-1:0]                 win_lvl;
  logic [IDX_W-1:0]                 win_idx;

  prio_regs #(
    .NUM_REGS       (NUM_REGS),
    .FIELDS_PER_REG (FIELDS_PER_REG),
    .LVL_W          (LVL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .field_lvl (field_lvl)
  );

  // An idle line competes at level 0, the same as a disabled source.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int FLD = field_of(i, NUM_SOLO, GROUP_SIZE);
    assign src_lvl[i] = irq_src[i] ? field_lvl[FLD] : '0;
  end

  prio_tree #(
    .N     (NUM_SRC),
    .LVL_W (LVL_W)
  ) u_tree (
    .lvl_in  (src_lvl),
    .win_lvl (win_lvl),
    .win_idx (win_idx)
  );

  irq_out_stage #(
    .N        (NUM_SRC),
    .LVL_W    (LVL_W),
    .VEC_W    (VEC_W),
    .NUM_EXT  (NUM_EXT),
    .VEC_BASE (VEC_BASE)
  ) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_lvl      (win_lvl),
    .win_idx      (win_idx),
    .sr_mask      (sr_mask),
    .ext_vec_mode (ext_vec_mode),
    .ext_vec      (ext_vec),
    .irq_ack      (irq_ack),
    .irq_req      (irq_req),
    .irq_level    (irq_level),
    .irq_vector   (irq_vector)
  );

  // R9
  idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_level == '0 || $past(irq_req)));

endmodule

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [23:0] irq_src = '0;
  logic [3:0]  sr_mask = '0;
  logic        ext_vec_mode = 1'b0;
  logic [7:0]  ext_vec = '0;
  logic        irq_req;
  logic        irq_ack = 1'b0;
  logic [3:0]  irq_level;
  logic [7:0]  irq_vector;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .irq_src      (irq_src),
    .sr_mask      (sr_mask),
    .ext_vec_mode (ext_vec_mode),
    .ext_vec      (ext_vec),
    .irq_req      (irq_req),
    .irq_ack      (irq_ack),
    .irq_level    (irq_level),
    .irq_vector   (irq_vector)
  );

  typedef struct packed {
    logic [7:0]  rq;
    logic [23:0] src;
    logic [3:0]  mask;
    logic        ext;
    logic [7:0]  ev;
    logic        e_req;
    logic [3:0]  e_lvl;
    logic [7:0]  e_vec;
  } row_t;

  // Levels: s0=2 s1=5 s2=5 s3=0 s4=7 s5=1 s6=9 s7=3 s8=9 s9=4 s10=6 s11=15
  // s12=8 s13=2 s14=10 s15=1, s16/17=12 s18/19=6 s20/21=3 s22/23=9
  localparam row_t TBL [15] = '{
    '{8'd4, 24'h000006, 4'd0,  1'b0, 8'h00, 1'b1, 4'd5,  8'h41}, // R4 tie s1/s2
    '{8'd3, 24'h000001, 4'd0,  1'b0, 8'h00, 1'b1, 4'd2,  8'h40}, // R3 single
    '{8'd3, 24'h000011, 4'd3,  1'b0, 8'h00, 1'b1, 4'd7,  8'h44}, // R3 higher level, higher index
    '{8'd4, 24'h000140, 4'd0,  1'b0, 8'h00, 1'b1, 4'd9,  8'h46}, // R4 tie s6/s8
    '{8'd3, 24'h004800, 4'd0,  1'b0, 8'h00, 1'b1, 4'd15, 8'h4B}, // R3
    '{8'd4, 24'h030000, 4'd0,  1'b0, 8'h00, 1'b1, 4'd12, 8'h50}, // R4 shared field
    '{8'd2, 24'h020000, 4'd0,  1'b0, 8'h00, 1'b1, 4'd12, 8'h51}, // R2 grouped source
    '{8'd6, 24'h000008, 4'd0,  1'b0, 8'h00, 1'b0, 4'd0,  8'h00}, // R6 level zero
    '{8'd5, 24'h000010, 4'd7,  1'b0, 8'h00, 1'b0, 4'd0,  8'h00}, // R5 equal held
    '{8'd5, 24'h000010, 4'd6,  1'b0, 8'h00, 1'b1, 4'd7,  8'h44}, // R5 held then forwarded
    '{8'd8, 24'h000002, 4'd0,  1'b1, 8'hA5, 1'b1, 4'd5,  8'hA5}, // R8 external
    '{8'd8, 24'h000010, 4'd0,  1'b1, 8'hA5, 1'b1, 4'd7,  8'h44}, // R8 internal source
    '{8'd7, 24'h800000, 4'd8,  1'b0, 8'h00, 1'b1, 4'd9,  8'h57}, // R7
    '{8'd9, 24'h000000, 4'd0,  1'b0, 8'h00, 1'b0, 4'd0,  8'h00}, // R9 nothing active
    '{8'd5, 24'h010800, 4'd15, 1'b0, 8'h00, 1'b0, 4'd0,  8'h00}  // R5 mask at top
  };

  task automatic chk(input string tag, input logic r, input logic [3:0] l, input logic [7:0] v);
    checks++;
    if (irq_req !== r || irq_level !== l || irq_vector !== v) begin
      fails++;
      $display("FAIL %s: got req=%0b lvl=%0d vec=%02h expected req=%0b lvl=%0d vec=%02h",
               tag, irq_req, irq_level, irq_vector, r, l, v);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got cycles=%0d expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    // R1 during reset
    repeat (2) @(negedge clk);
    chk("R1 in reset", 1'b0, 4'd0, 8'h00);
    rst_n = 1'b1;
    irq_src = 24'hFFFFFF;
    @(negedge clk);
    @(negedge clk);
    // R1 all fields reset to zero: nothing forwarded
    chk("R1 fields zero", 1'b0, 4'd0, 8'h00);
    irq_src = '0;

    // R2 program the bank
    wr(3'd0, 16'h0552);
    wr(3'd1, 16'h3917);
    wr(3'd2, 16'hF649);
    wr(3'd3, 16'h1A28);
    wr(3'd4, 16'h936C);

    for (int i = 0; i < 15; i++) begin
      irq_src = TBL[i].src;
      sr_mask = TBL[i].mask;
      ext_vec_mode = TBL[i].ext;
      ext_vec = TBL[i].ev;
      @(negedge clk);
      chk($sformatf("R%0d row %0d", TBL[i].rq, i), TBL[i].e_req, TBL[i].e_lvl, TBL[i].e_vec);
    end
    ext_vec_mode = 1'b0;
    sr_mask = 4'd0;

    // R2 out-of-range writes leave the bank unchanged
    wr(3'd5, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    irq_src = 24'h000008;
    @(negedge clk);
    chk("R2 addr5/7 ignored s3", 1'b0, 4'd0, 8'h00);
    irq_src = 24'h000020;
    @(negedge clk);
    chk("R2 addr5/7 ignored s5", 1'b1, 4'd1, 8'h45);

    // R2 rewrite of register 0, then R4 tie at the top level
    wr(3'd0, 16'h055F);
    irq_src = 24'h000801;
    @(negedge clk);
    chk("R4 tie at 15 s0/s11", 1'b1, 4'd15, 8'h40);

    // R9 registered: new input not visible before the edge
    irq_src = 24'h000010;
    #1;
    chk("R9 before edge", 1'b1, 4'd15, 8'h40);
    @(negedge clk);
    chk("R9 after edge", 1'b1, 4'd7, 8'h44);

    // R10 handshake
    irq_ack = 1'b1;
    @(negedge clk);
    chk("R10 held cycle", 1'b0, 4'd7, 8'h44);
    irq_ack = 1'b0;
    irq_src = 24'h000810;
    @(negedge clk);
    chk("R10 resumed", 1'b1, 4'd15, 8'h4B);

    // R10 ack with no request is ignored
    irq_src = '0;
    @(negedge clk);
    chk("R10 idle", 1'b0, 4'd0, 8'h00);
    irq_ack = 1'b1;
    irq_src = 24'h000010;
    @(negedge clk);
    chk("R10 ack ignored", 1'b1, 4'd7, 8'h44);
    irq_ack = 1'b0;

    // R1 reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reapplied", 1'b0, 4'd0, 8'h00);

    finish_run();
  end

endmodule